// File: doc/BRIEF.md
# Operate Unit with Condition Codes

This block is the arithmetic and logic stage for the register-to-register operate class of a small 16-bit load/store machine. It carries out three operations: addition, bitwise AND and bitwise complement. The block takes the raw 16-bit instruction word and gives out the two source register indices taken from it. An external register file, with eight entries, returns two operand words for those indices. From these the block forms the 16-bit result, the destination index and a write strobe, all in the same cycle.

For addition and AND, one bit in the instruction chooses the second operand. That operand is either the second register value or a 5-bit constant that is sign-extended to the data width. The complement uses only the first source, and its destination may name the same register. The block holds a 3-bit condition-code register. On the clock edge of every write, this register records whether the written value is negative, zero or positive. Exactly one of the three flags is set at any time. An opcode outside the three supported ones writes nothing and leaves the flags as they were.

Top module: `operate_unit`

## Requirements
- R1: When `instr[15:12]` is 4'b0001 and `instr[5]` is 0, `result` equals `src_a + src_b` modulo 2^16. `wr_en` is 1 and `dest_idx` equals `instr[11:9]`.
- R2: When `instr[15:12]` is 4'b0001 and `instr[5]` is 1, `result` equals `src_a` plus `instr[4:0]` sign-extended to 16 bits. `src_b` has no effect on `result`.
- R3: When `instr[15:12]` is 4'b0101, `result` is the bitwise AND of `src_a` with a second operand. That operand is `src_b` when `instr[5]` is 0 and the sign-extended `instr[4:0]` when `instr[5]` is 1. `wr_en` is 1.
- R4: When `instr[15:12]` is 4'b1001, `result` equals `~src_a` and `wr_en` is 1. `instr[5:0]` and `src_b` have no effect.
- R5: `rd_idx_a` always equals `instr[8:6]`, and `rd_idx_b` always equals `instr[2:0]`.
- R6: For any other opcode, `wr_en` is 0 and `cc` keeps its value across the clock edge.
- R7: On a rising edge with `wr_en` at 1 and `rst` at 0, `cc` is loaded as follows. The encoding is `cc[2]`=N, `cc[1]`=Z, `cc[0]`=P. The value is 3'b100 when `result` is negative as two's complement, 3'b010 when it is zero, and 3'b001 when it is positive.
- R8: Synchronous active-high `rst` sets `cc` to 3'b010. Reset takes priority over any write in the same cycle.
- R9: Exactly one bit of `cc` is set in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 16 | Instruction word |
| src_a | input | 16 | Register value read at `rd_idx_a` |
| src_b | input | 16 | Register value read at `rd_idx_b` |
| rd_idx_a | output | 3 | First source register index |
| rd_idx_b | output | 3 | Second source register index |
| result | output | 16 | Operation result to write back |
| dest_idx | output | 3 | Destination register index |
| wr_en | output | 1 | Write strobe for the result |
| cc | output | 3 | Condition flags {N,Z,P} |

## Verification
The adder is driven with small positive operands, with a signed overflow from 0x7FFF to 0x8000, and with a carry-out that wraps to zero. This separates true 16-bit modulo arithmetic from a widened or saturating adder. Immediate cases use the constants -1, -16, 15 and 0, each paired with a `src_b` value that differs clearly from the constant. These show whether sign extension happens and whether the mode bit really steers the operand. Complement cases run with the low six bits both all ones and all zeros, to show that those bits are ignored. Unsupported opcodes follow results of each sign, so the flags they must keep are sometimes Z and sometimes N, and a stray update shows up.

// File: rtl/operate_unit_pkg.sv
package operate_unit_pkg;

    localparam int INSTR_W = 16;
    localparam int IDX_W   = 3;
    localparam int IMM_W   = 5;
    localparam int CC_W    = 3;

    localparam logic [3:0] OPC_ADD = 4'b0001;
    localparam logic [3:0] OPC_AND = 4'b0101;
    localparam logic [3:0] OPC_NOT = 4'b1001;

    localparam logic [CC_W-1:0] CC_RESET = 3'b010;

    typedef enum logic [1:0] {
        ALU_NONE = 2'd0,
        ALU_ADD  = 2'd1,
        ALU_AND  = 2'd2,
        ALU_NOT  = 2'd3
    } alu_op_e;

    typedef struct packed {
        logic [3:0]       opcode;
        logic [IDX_W-1:0] dst;
        logic [IDX_W-1:0] sr1;
        logic             imm_sel;
        logic [IMM_W-1:0] imm;
    } instr_fields_t;

    typedef struct packed {
        logic n;
        logic z;
        logic p;
    } cc_t;

    function automatic alu_op_e op_of(input logic [3:0] opc);
        case (opc)
            OPC_ADD: op_of = ALU_ADD;
            OPC_AND: op_of = ALU_AND;
            OPC_NOT: op_of = ALU_NOT;
            default: op_of = ALU_NONE;
        endcase
    endfunction

endpackage

// File: rtl/operate_unit_decode.sv
module operate_unit_decode
    import operate_unit_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [INSTR_W-1:0] instr,
    output alu_op_e            op,
    output logic [IDX_W-1:0]   dst,
    output logic [IDX_W-1:0]   sr1,
    output logic [IDX_W-1:0]   sr2,
    output logic               use_imm,
    output logic [DATA_W-1:0]  imm_ext,
    output logic               wr_en
);

    instr_fields_t f;

    always_comb begin
        f       = instr_fields_t'(instr);
        op      = op_of(f.opcode);
        dst     = f.dst;
        sr1     = f.sr1;
        sr2     = f.imm[IDX_W-1:0];
        use_imm = f.imm_sel;
        imm_ext = {{(DATA_W-IMM_W){f.imm[IMM_W-1]}}, f.imm};
        wr_en   = (op != ALU_NONE);
    end

endmodule

// File: rtl/operate_unit_alu.sv
module operate_unit_alu
    import operate_unit_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_reg,
    input  logic [DATA_W-1:0] imm_ext,
    input  logic              use_imm,
    output logic [DATA_W-1:0] result
);

    logic [DATA_W-1:0] opnd_b;

    always_comb begin
        opnd_b = use_imm ? imm_ext : opnd_reg;
        case (op)
            ALU_ADD: result = opnd_a + opnd_b;
            ALU_AND: result = opnd_a & opnd_b;
            ALU_NOT: result = ~opnd_a;
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/operate_unit_ccreg.sv
module operate_unit_ccreg
    import operate_unit_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] value,
    output cc_t               cc
);

    cc_t cc_next;

    always_comb begin
        cc_next.n = value[DATA_W-1];
        cc_next.z = (value == '0);
        cc_next.p = ~value[DATA_W-1] & (value != '0);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cc <= cc_t'(CC_RESET);
        else if (load)
            cc <= cc_next;
    end

endmodule

// File: rtl/operate_unit.sv
module operate_unit
    import operate_unit_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  src_a,
    input  logic [DATA_W-1:0]  src_b,
    output logic [IDX_W-1:0]   rd_idx_a,
    output logic [IDX_W-1:0]   rd_idx_b,
    output logic [DATA_W-1:0]  result,
    output logic [IDX_W-1:0]   dest_idx,
    output logic               wr_en,
    output logic [CC_W-1:0]    cc
);

    alu_op_e           op;
    logic              use_imm;
    logic [DATA_W-1:0] imm_ext;
    cc_t               cc_q;

    operate_unit_decode #(.DATA_W(DATA_W)) u_decode (
        .instr   (instr),
        .op      (op),
        .dst     (dest_idx),
        .sr1     (rd_idx_a),
        .sr2     (rd_idx_b),
        .use_imm (use_imm),
        .imm_ext (imm_ext),
        .wr_en   (wr_en)
    );

    operate_unit_alu #(.DATA_W(DATA_W)) u_alu (
        .op       (op),
        .opnd_a   (src_a),
        .opnd_reg (src_b),
        .imm_ext  (imm_ext),
        .use_imm  (use_imm),
        .result   (result)
    );

    operate_unit_ccreg #(.DATA_W(DATA_W)) u_ccreg (
        .clk   (clk),
        .rst   (rst),
        .load  (wr_en),
        .value (result),
        .cc    (cc_q)
    );

    assign cc = cc_q;

endmodule

// File: rtl/operate_unit_chk.sv
module operate_unit_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [15:0]       instr,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic [DATA_W-1:0] result,
    input logic [2:0]        dest_idx,
    input logic              wr_en,
    input logic [2:0]        cc
);

    // R9
    cc_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(cc) == 1);

    // R7
    cc_from_result_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (cc[2] == $past(result[DATA_W-1])) &&
                  (cc[1] == ($past(result) == '0)));

    // R6
    cc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cc));

    // R6
    legal_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (instr[15:12] == 4'b0001 || instr[15:12] == 4'b0101 ||
                   instr[15:12] == 4'b1001));

    // R8
    reset_cc_chk: assert property (@(posedge clk)
        rst |=> cc == 3'b010);

    // R1
    add_reg_chk: assert property (@(posedge clk) disable iff (rst)
        (instr[15:12] == 4'b0001 && !instr[5]) |->
            (result == src_a + src_b) && wr_en && dest_idx == instr[11:9]);

    // R4
    not_chk: assert property (@(posedge clk) disable iff (rst)
        (instr[15:12] == 4'b1001) |-> (result == ~src_a) && wr_en);

endmodule

bind operate_unit operate_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .instr    (instr),
    .src_a    (src_a),
    .src_b    (src_b),
    .result   (result),
    .dest_idx (dest_idx),
    .wr_en    (wr_en),
    .cc       (cc)
);

// File: tb/operate_unit_tb.sv
`timescale 1ns/1ps
module operate_unit_tb;

    typedef struct packed {
        logic [15:0] ins;
        logic [15:0] a;
        logic [15:0] b;
        logic [15:0] res;
        logic        wr;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{16'h1283, 16'h0005, 16'h0007, 16'h000C, 1'b1}, // ADD reg
        '{16'h11C6, 16'h7FFF, 16'h0001, 16'h8000, 1'b1}, // ADD overflow
        '{16'h147F, 16'h0001, 16'hAAAA, 16'h0000, 1'b1}, // ADD imm -1
        '{16'h16EF, 16'hFFF0, 16'h1234, 16'hFFFF, 1'b1}, // ADD imm 15
        '{16'h1970, 16'h0020, 16'h0FFF, 16'h0010, 1'b1}, // ADD imm -16
        '{16'h5B87, 16'hF0F0, 16'h3C3C, 16'h3030, 1'b1}, // AND reg
        '{16'h5C3F, 16'h8421, 16'h0000, 16'h8421, 1'b1}, // AND imm -1
        '{16'h0E05, 16'h0001, 16'h0001, 16'h0000, 1'b0}, // opcode 0 after N
        '{16'h5E60, 16'h1234, 16'hFFFF, 16'h0000, 1'b1}, // AND imm 0
        '{16'h50A5, 16'hFFFE, 16'h0000, 16'h0004, 1'b1}, // AND imm 5
        '{16'h993F, 16'h00FF, 16'h1111, 16'hFF00, 1'b1}, // NOT same reg
        '{16'hF025, 16'h0000, 16'h0000, 16'h0000, 1'b0}, // opcode F after N
        '{16'h9280, 16'hFFFF, 16'h5555, 16'h0000, 1'b1}, // NOT low bits 0
        '{16'h6283, 16'h7000, 16'h0100, 16'h0000, 1'b0}, // opcode 6 after Z
        '{16'h1283, 16'h8000, 16'h8000, 16'h0000, 1'b1}  // ADD carry wrap
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] instr = 16'h0000;
    logic [15:0] src_a = 16'h0000;
    logic [15:0] src_b = 16'h0000;
    logic [2:0]  rd_idx_a, rd_idx_b, dest_idx, cc;
    logic [15:0] result;
    logic        wr_en;

    int n_chk = 0;
    int n_bad = 0;
    logic [2:0] model_cc;

    always #5 clk = ~clk;

    operate_unit u_dut (
        .clk(clk), .rst(rst), .instr(instr), .src_a(src_a), .src_b(src_b),
        .rd_idx_a(rd_idx_a), .rd_idx_b(rd_idx_b), .result(result),
        .dest_idx(dest_idx), .wr_en(wr_en), .cc(cc)
    );

    function automatic logic [2:0] sign_class(input logic [15:0] v);
        if ($signed(v) < 0)  return 3'b100;
        if (v == 16'h0000)   return 3'b010;
        return 3'b001;
    endfunction

    task automatic chk(input string req, input logic [15:0] act,
                       input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        string tag;
        // R8: reset state
        repeat (3) @(negedge clk);
        chk("R8 reset cc", {13'd0, cc}, 16'h0002);
        chk("R6 opcode 0 no write", {15'd0, wr_en}, 16'h0000);
        rst = 1'b0;
        model_cc = 3'b010;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            instr = VECS[i].ins;
            src_a = VECS[i].a;
            src_b = VECS[i].b;
            #1;
            case (VECS[i].ins[15:12])
                4'b0001: tag = VECS[i].ins[5] ? "R2" : "R1";
                4'b0101: tag = "R3";
                4'b1001: tag = "R4";
                default: tag = "R6";
            endcase
            chk({tag, " wr_en"}, {15'd0, wr_en}, {15'd0, VECS[i].wr});
            if (VECS[i].wr) begin
                chk({tag, " result"}, result, VECS[i].res);
                chk({tag, " dest"}, {13'd0, dest_idx}, {13'd0, VECS[i].ins[11:9]});
                model_cc = sign_class(VECS[i].res);
            end
            chk("R5 idx a", {13'd0, rd_idx_a}, {13'd0, VECS[i].ins[8:6]});
            chk("R5 idx b", {13'd0, rd_idx_b}, {13'd0, VECS[i].ins[2:0]});
            @(negedge clk);
            chk(VECS[i].wr ? "R7 cc update" : "R6 cc hold", {13'd0, cc},
                {13'd0, model_cc});
            chk("R9 cc onehot", 16'($countones(cc)), 16'd1);
        end

        // R2: src_b ignored in immediate mode, changed with same instr
        @(negedge clk);
        instr = 16'h147F; src_a = 16'h0010; src_b = 16'h0000;
        #1 chk("R2 imm ignores src_b", result, 16'h000F);
        src_b = 16'hFFFF;
        #1 chk("R2 imm ignores src_b", result, 16'h000F);

        // R8: reset wins over a write producing N
        @(negedge clk);
        instr = 16'h11C6; src_a = 16'h7FFF; src_b = 16'h0001;
        @(negedge clk);
        chk("R7 cc N", {13'd0, cc}, 16'h0004);
        rst = 1'b1;
        @(negedge clk);
        chk("R8 reset priority", {13'd0, cc}, 16'h0002);
        rst = 1'b0;
        @(negedge clk);
        chk("R7 after reset", {13'd0, cc}, 16'h0004);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule